// File: doc/BRIEF.md
# Amplitude Scaling and Dither Stage

This stage conditions the amplitude words coming out of a sine lookup table before they reach a converter with fewer bits. Each accepted sample is multiplied by a programmable gain, rounded, and may then receive a small pseudo-random offset. The result is requantized to the converter width, and values outside its range are clipped instead of wrapping.

The gain word is unsigned, with 1.0 at 2048, so the usable gain range is from zero to just under two. The dither comes from a 16-bit linear-feedback register. While dither is off, that register takes the seed input, so the dithered sequence can be repeated. The path is a two-stage pipeline: each input sample gives exactly one output sample two clocks later, and the output holds its last value between samples.

Top module: `amp_dither_stage`

## Requirements
- R1: On an accepted sample (`amp_valid_i` high), the scaled value is `floor((amp_i * am_scale_i + 1024) / 2048)`. `amp_i` is a 14-bit two's-complement number and `am_scale_i` is unsigned. A gain of 0 gives 0, and a gain of 2048 passes the amplitude through unchanged.
- R2: With `dith_en_i` low, the output code is `floor((scaled + 2) / 4)`, taken as a 12-bit two's-complement value (rounding half up).
- R3: When the requantized value is above 2047 the output is 2047. When it is below -2048 the output is -2048. The output never wraps.
- R4: With `dith_en_i` high, a value `d` is added to the scaled value before requantization: `floor((scaled + d + 2) / 4)`. `d` is bits [1:0] of the current register state read as a 2-bit two's-complement number (-2..+1), so its magnitude is at most half an output LSB.
- R5: The dither register is a right-shifting Galois register. On a step, if bit 0 is 1 the next state is `(s >> 1) ^ 16'hB400`, otherwise it is `s >> 1`. It steps once per accepted sample while dither is enabled, after its current state has supplied that sample's `d`. It never reaches zero.
- R6: On every clock with `dith_en_i` low, the register loads `dith_seed_i`, or 16'hACE1 when the seed is zero. While dither is enabled, the seed input has no effect.
- R7: `dac_valid_o` is `amp_valid_i` delayed by exactly two clocks, and every accepted sample produces exactly one output.
- R8: On clocks that carry no new output, `dac_o` keeps its previous value.
- R9: After reset, `dac_valid_o` is 0, `dac_o` is 0 and the dither register holds 16'hACE1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| amp_valid_i | input | 1 | Input sample valid |
| amp_i | input | 14 | Signed amplitude from the sine table |
| am_scale_i | input | 12 | Unsigned gain, 2048 = 1.0 |
| dith_en_i | input | 1 | Dither enable |
| dith_seed_i | input | 16 | Dither register seed, loaded while dither is off |
| dac_valid_o | output | 1 | Output code valid |
| dac_o | output | 12 | Signed converter code |

## Verification
The assertions check on every cycle that:
- the valid pipeline is exactly two clocks deep;
- the output holds between samples;
- the dither register is never zero, holds when no sample arrives, and loads the default for a zero seed;
- zero and unity gain behave as stated;
- amplitudes far enough past either rail clip.

Only the bench scenarios can show the exact arithmetic. This covers half-way rounding of negative values, saturation near the rail, and the bit-exact dither sequence, including that the seed is ignored while dither is on and that reseeding restarts the sequence.

// File: rtl/amp_dither_pkg.sv
package amp_dither_pkg;
  localparam int unsigned     LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_DFLT = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] sh;
    sh = s >> 1;
    return s[0] ? (sh ^ LFSR_MASK) : sh;
  endfunction
endpackage

// File: rtl/am_scale.sv
module am_scale #(
  parameter int unsigned AMP_W   = 14,
  parameter int unsigned SCALE_W = 12,
  parameter int unsigned DITH_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [AMP_W-1:0] amp_i,
  input  logic [SCALE_W-1:0]      scale_i,
  input  logic signed [DITH_W-1:0] dith_i,
  output logic                    valid_o,
  output logic signed [AMP_W:0]   amp_o,
  output logic signed [DITH_W-1:0] dith_o
);
  localparam int unsigned PROD_W = AMP_W + SCALE_W + 1;
  localparam int unsigned SHIFT  = SCALE_W - 1;
  localparam int unsigned OUT_W  = AMP_W + 1;
  localparam logic signed [PROD_W-1:0] HALF =
    {{(PROD_W-1){1'b0}}, 1'b1} <<< (SHIFT - 1);
  localparam logic [SCALE_W-1:0] UNITY = {1'b1, {(SCALE_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;

  always_comb prod = PROD_W'($signed(amp_i) * $signed({1'b0, scale_i}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      amp_o   <= '0;
      dith_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        amp_o  <= OUT_W'((prod + HALF) >>> SHIFT);
        dith_o <= dith_i;
      end
    end
  end

  // R1
  scale_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scale_i == '0) |=> (amp_o == '0));
  // R1
  scale_unity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scale_i == UNITY) |=> (amp_o == OUT_W'($past(amp_i))));
endmodule

// File: rtl/dither_lfsr.sv
module dither_lfsr
  import amp_dither_pkg::*;
#(
  parameter int unsigned DITH_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     step_i,
  input  logic [LFSR_W-1:0]        seed_i,
  output logic signed [DITH_W-1:0] dith_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= LFSR_DFLT;
    else if (!en_i)   state_q <= (seed_i == '0) ? LFSR_DFLT : seed_i;
    else if (step_i)  state_q <= lfsr_step(state_q);
  end

  always_comb dith_o = en_i ? $signed(state_q[DITH_W-1:0]) : '0;

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  // R5
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(state_q));
  // R6
  seed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && seed_i == '0) |=> (state_q == LFSR_DFLT));
endmodule

// File: rtl/dac_quant.sv
module dac_quant #(
  parameter int unsigned IN_W   = 15,
  parameter int unsigned DITH_W = 2,
  parameter int unsigned DAC_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [IN_W-1:0]   amp_i,
  input  logic signed [DITH_W-1:0] dith_i,
  output logic                     valid_o,
  output logic signed [DAC_W-1:0]  dac_o
);
  localparam int unsigned FRAC  = IN_W - 1 - DAC_W;
  localparam int unsigned SUM_W = IN_W + 2;
  localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(1) <<< (FRAC - 1);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (DAC_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -MAX_V - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] HI_LIM = (MAX_V + SUM_W'(1)) <<< FRAC;
  localparam logic signed [SUM_W-1:0] LO_LIM = (MIN_V <<< FRAC) - (SUM_W'(1) <<< FRAC);

  logic signed [SUM_W-1:0] sum, rnd, amp_x;
  logic signed [DAC_W-1:0] dac_d;

  always_comb begin
    amp_x = SUM_W'(amp_i);
    sum   = amp_x + SUM_W'(dith_i) + HALF;
    rnd   = sum >>> FRAC;
    if (rnd > MAX_V)      dac_d = DAC_W'(MAX_V);
    else if (rnd < MIN_V) dac_d = DAC_W'(MIN_V);
    else                  dac_d = DAC_W'(rnd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dac_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dac_o <= dac_d;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dac_o));
  // R3
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amp_x >= HI_LIM) |=> (dac_o == DAC_W'(MAX_V)));
  // R3
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amp_x <= LO_LIM) |=> (dac_o == DAC_W'(MIN_V)));
endmodule

// File: rtl/amp_dither_stage.sv
module amp_dither_stage
  import amp_dither_pkg::*;
#(
  parameter int unsigned AMP_W   = 14,
  parameter int unsigned SCALE_W = 12,
  parameter int unsigned DAC_W   = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    amp_valid_i,
  input  logic signed [AMP_W-1:0] amp_i,
  input  logic [SCALE_W-1:0]      am_scale_i,
  input  logic                    dith_en_i,
  input  logic [LFSR_W-1:0]       dith_seed_i,
  output logic                    dac_valid_o,
  output logic signed [DAC_W-1:0] dac_o
);
  localparam int unsigned DITH_W = AMP_W - DAC_W;
  localparam int unsigned MID_W  = AMP_W + 1;

  logic signed [DITH_W-1:0] dith_raw, dith_s1;
  logic signed [MID_W-1:0]  amp_s1;
  logic                     valid_s1;

  dither_lfsr #(.DITH_W(DITH_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dith_en_i),
    .step_i (amp_valid_i),
    .seed_i (dith_seed_i),
    .dith_o (dith_raw)
  );

  am_scale #(.AMP_W(AMP_W), .SCALE_W(SCALE_W), .DITH_W(DITH_W)) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (amp_valid_i),
    .amp_i   (amp_i),
    .scale_i (am_scale_i),
    .dith_i  (dith_raw),
    .valid_o (valid_s1),
    .amp_o   (amp_s1),
    .dith_o  (dith_s1)
  );

  dac_quant #(.IN_W(MID_W), .DITH_W(DITH_W), .DAC_W(DAC_W)) u_quant (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_s1),
    .amp_i   (amp_s1),
    .dith_i  (dith_s1),
    .valid_o (dac_valid_o),
    .dac_o   (dac_o)
  );

  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_i |=> ##1 dac_valid_o);
  // R7
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_valid_i |=> ##1 !dac_valid_o);
endmodule

// File: tb/sim_amp_dither_stage.sv
`timescale 1ns/1ps
module sim_amp_dither_stage;
  typedef struct {
    int    exp;
    string req;
  } item_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               vin = 1'b0;
  logic signed [13:0] amp = '0;
  logic [11:0]        scl = '0;
  logic               en = 1'b0;
  logic [15:0]        seed = '0;
  logic               vout;
  logic signed [11:0] dac;

  int     n_chk = 0, n_fail = 0;
  item_t  q[$];
  logic [15:0] m_lfsr = 16'hACE1;
  int     last_dac = 0;
  bit     mon_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  amp_dither_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .amp_valid_i(vin), .amp_i(amp),
    .am_scale_i(scl), .dith_en_i(en), .dith_seed_i(seed),
    .dac_valid_o(vout), .dac_o(dac)
  );

  function automatic logic [15:0] gal(input logic [15:0] s);
    if (s[0]) return (s >> 1) ^ 16'hB400;
    return s >> 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the sample, wait next negedge
  task automatic tick(input bit v, input int a, input int s, input string req);
    item_t it;
    int p, d, r;
    vin = v; amp = 14'(a); scl = 12'(s);
    if (v) begin
      p = (a * s + 1024) >>> 11;
      d = 0;
      if (en) d = m_lfsr[1] ? int'(m_lfsr[1:0]) - 4 : int'(m_lfsr[1:0]);
      r = (p + d + 2) >>> 2;
      if (r > 2047) r = 2047;
      if (r < -2048) r = -2048;
      it.exp = r; it.req = req;
      q.push_back(it);
    end
    if (!en) m_lfsr = (seed == 16'h0) ? 16'hACE1 : seed;
    else if (v) m_lfsr = gal(m_lfsr);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (vout) begin
        if (q.size() == 0) check(1'b0, "R7", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          check(int'(dac) == it.exp, it.req, int'(dac), it.exp);
        end
        last_dac = int'(dac);
      end else begin
        check(int'(dac) == last_dac, "R8", int'(dac), last_dac);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    check(vout == 1'b0, "R9", int'(vout), 0);
    check(int'(dac) == 0, "R9", int'(dac), 0);
    mon_on = 1'b1;

    en = 1'b0; seed = 16'h1234;
    // R2 rounding at unity gain, incl. negative halves
    tick(1, 1000, 2048, "R2");
    tick(1, -1000, 2048, "R2");
    tick(1, 6, 2048, "R2");
    tick(1, 5, 2048, "R2");
    tick(1, -6, 2048, "R2");
    tick(1, -7, 2048, "R2");
    tick(0, 0, 0, "R8");
    tick(0, 0, 0, "R8");
    // R1 gain values
    tick(1, 3000, 1024, "R1");
    tick(1, -4001, 3000, "R1");
    tick(1, 7777, 0, "R1");
    tick(1, 4097, 1, "R1");
    tick(0, 0, 0, "R8");
    // R3 saturation both rails and just inside
    tick(1, 8191, 4095, "R3");
    tick(1, -8192, 4095, "R3");
    tick(1, 8190, 2048, "R3");
    tick(1, -8192, 2048, "R3");
    tick(1, 4096, 4095, "R3");
    tick(1, -4097, 4095, "R3");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, "R8");

    // R4/R5 dither from loaded seed, with gaps
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick(1, (i * 397) % 8000 - 4000, 2048 + i * 13, "R4");
      if (i % 5 == 0) tick(0, 0, 0, "R5");
    end
    // R6 seed ignored while enabled
    seed = 16'hFFFF;
    for (int i = 0; i < 20; i++) tick(1, 2 * i - 19, 2048, "R6");
    // R6 zero seed reload, then R3 near rail with dither
    en = 1'b0; seed = 16'h0000;
    tick(0, 0, 0, "R6");
    en = 1'b1;
    for (int i = 0; i < 24; i++) tick(1, 8189 - (i % 4), 2048, "R3");
    for (int i = 0; i < 24; i++) tick(1, i * 3 - 36, 2048, "R5");
    en = 1'b0;
    for (int i = 0; i < 5; i++) tick(0, 0, 0, "R8");
    // R7 every sample came out
    check(q.size() == 0, "R7", q.size(), 0);
    finish_run();
  end
endmodule